// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block merges every reason a system may need a reset into one reset pulse of fixed length. There are four sources: a power-on condition, a digital supply-fail flag from an external comparator, a debounced push-button request, and a watchdog expiry strobe. A millisecond tick from elsewhere on the chip paces the pulse length. While the supply flag is true the reset is held. After the flag clears, the reset is stretched for a long fixed interval. The default is 610 ticks, inside the permitted window of 250 to 1000 ms.

The block drives an active-high reset and its inverse. The inverse is meant for an open-drain pad, which can only pull low, so the block also provides an active-low enable for that pad driver. When the reset ends, the block emits a single-cycle release pulse so that a watchdog can restart its timing from zero. The tick spacing is fixed by the tick source, and the pulse length is the parameter `HOLD_TICKS`.

Top module: `rst_pulse_gen`

## Requirements
- R1: While `por_n` is low, `rst_hi` is 1. After `por_n` rises, `rst_hi` stays 1 until `HOLD_TICKS` ticks have been sampled.
- R2: `supply_fail` sampled high at a clock edge makes `rst_hi` 1 after that same edge, whether or not a tick is present.
- R3: While `supply_fail` stays high, `rst_hi` stays 1 and ticks do not shorten the pulse.
- R4: After the last edge that samples `supply_fail` high, `rst_hi` falls at the edge that samples the `HOLD_TICKS`-th later tick.
- R5: `button_req` sampled high starts a reset pulse of `HOLD_TICKS` ticks, with the same timing as R4.
- R6: `wdog_expire` sampled high starts a reset pulse of the same length as R5.
- R7: Any request sampled while `rst_hi` is already 1 restarts the count from `HOLD_TICKS`.
- R8: `rst_lo` is always the inverse of `rst_hi`. `rst_lo_oe_n` is 0, meaning the pad pulls low, exactly when `rst_hi` is 1.
- R9: `released` is 1 for exactly one cycle: the first cycle in which `rst_hi` is 0 after being 1.
- R10: While `rst_hi` is 0 and no request is present, ticks have no effect and `rst_hi` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on condition, active low, asynchronous |
| tick_ms | input | 1 | One-cycle tick, nominally every millisecond |
| supply_fail | input | 1 | Supply below threshold, from an external comparator |
| button_req | input | 1 | Debounced push-button reset request |
| wdog_expire | input | 1 | Watchdog timeout strobe |
| rst_hi | output | 1 | Active-high reset |
| rst_lo | output | 1 | Inverse of `rst_hi` |
| rst_lo_oe_n | output | 1 | Active-low enable of the open-drain pull-down for `rst_lo` |
| released | output | 1 | One-cycle pulse when the reset ends |

## Verification
A wrong tick count would show as a reset edge that falls one or more tick periods too early or too late after the last request. An off-by-one in the reload or the terminal compare would be visible at the first stretched pulse. A missed reload would let a request made during an active pulse end that pulse early, and this would be seen within one tick period of the expected end. A stuck active flag would show as `rst_hi` never falling, or as ticks ending an idle state. A broken release path would show as a `released` pulse that is missing, doubled, or misplaced relative to the falling edge of `rst_hi`, and this would be seen in the same cycle.

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int HOLD_TICKS = 610
) (
  input  logic clk,
  input  logic por_n,
  input  logic tick_ms,
  input  logic supply_fail,
  input  logic button_req,
  input  logic wdog_expire,
  output logic rst_hi,
  output logic rst_lo,
  output logic rst_lo_oe_n,
  output logic released
);
  localparam int CW = $clog2(HOLD_TICKS + 1);

  logic [CW-1:0] cnt;
  logic          active;
  logic          reload, last_tick;

  assign reload    = supply_fail | button_req | wdog_expire;
  assign last_tick = active & tick_ms & (cnt == CW'(1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      active   <= 1'b1;
      cnt      <= CW'(HOLD_TICKS);
      released <= 1'b0;
    end else begin
      released <= 1'b0;
      if (reload) begin
        active <= 1'b1;
        cnt    <= CW'(HOLD_TICKS);
      end else if (last_tick) begin
        active   <= 1'b0;
        cnt      <= '0;
        released <= 1'b1;
      end else if (active && tick_ms) begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  assign rst_hi      = active;
  assign rst_lo      = ~active;
  assign rst_lo_oe_n = ~active;
endmodule

// File: rtl/rst_pulse_gen_chk.sv
module rst_pulse_gen_chk (
  input logic clk,
  input logic por_n,
  input logic supply_fail,
  input logic button_req,
  input logic wdog_expire,
  input logic rst_hi,
  input logic rst_lo,
  input logic rst_lo_oe_n,
  input logic released
);
  a_r8_inverse: assert property (@(posedge clk) disable iff (!por_n)
    (rst_lo != rst_hi) && (rst_lo_oe_n != rst_hi));
  a_r2_fail_asserts: assert property (@(posedge clk) disable iff (!por_n)
    supply_fail |=> rst_hi);
  a_r5_r6_request_asserts: assert property (@(posedge clk) disable iff (!por_n)
    (button_req || wdog_expire) |=> rst_hi);
  a_r9_release_single: assert property (@(posedge clk) disable iff (!por_n)
    released |=> !released);
  a_r9_release_on_fall: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_hi) |-> released);
  a_r10_idle_stays: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_hi && !supply_fail && !button_req && !wdog_expire) |=> !rst_hi);
endmodule

bind rst_pulse_gen rst_pulse_gen_chk u_chk (
  .clk(clk), .por_n(por_n), .supply_fail(supply_fail),
  .button_req(button_req), .wdog_expire(wdog_expire),
  .rst_hi(rst_hi), .rst_lo(rst_lo), .rst_lo_oe_n(rst_lo_oe_n),
  .released(released)
);

// File: tb/test_rst_pulse_gen.sv
module test_rst_pulse_gen;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 5;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic por_n = 1'b0, tick_ms = 1'b0, supply_fail = 1'b0;
  logic button_req = 1'b0, wdog_expire = 1'b0;
  logic rst_hi, rst_lo, rst_lo_oe_n, released;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 1'b0;
  bit m_active = 1'b1, m_rel = 1'b0;
  int m_left = HOLD;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_pulse_gen #(.HOLD_TICKS(HOLD)) i_rst_pulse_gen (
    .clk(clk), .por_n(por_n), .tick_ms(tick_ms), .supply_fail(supply_fail),
    .button_req(button_req), .wdog_expire(wdog_expire), .rst_hi(rst_hi),
    .rst_lo(rst_lo), .rst_lo_oe_n(rst_lo_oe_n), .released(released));

  function automatic bit req_now(bit f, bit b, bit w);
    return f | b | w;
  endfunction

  task automatic expect1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic check_all(string req);
    expect1(req, rst_hi, m_active);
    expect1("R8", rst_lo, ~m_active);
    expect1("R8", rst_lo_oe_n, ~m_active);
    expect1("R9", released, m_rel);
  endtask

  task automatic step(string req, bit t, bit f, bit b, bit w);
    tick_ms = t; supply_fail = f; button_req = b; wdog_expire = w;
    @(posedge clk);
    m_rel = 1'b0;
    if (req_now(f, b, w)) begin
      m_active = 1'b1; m_left = HOLD;
    end else if (m_active && t) begin
      m_left--;
      if (m_left == 0) begin m_active = 1'b0; m_rel = 1'b1; end
    end
    cycles++;
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1");
    por_n = 1'b1;
    for (int i = 0; i < HOLD; i++) begin
      step("R1", 1'b0, 1'b0, 1'b0, 1'b0);
      step("R1", 1'b1, 1'b0, 1'b0, 1'b0);
    end
    step("R9", 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) step("R10", 1'b1, 1'b0, 1'b0, 1'b0);
    step("R2", 1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 12; i++) step("R3", 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < HOLD + 2; i++) step("R4", 1'b1, 1'b0, 1'b0, 1'b0);
    step("R5", 1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < HOLD + 2; i++) step("R5", 1'b1, 1'b0, 1'b0, 1'b0);
    step("R6", 1'b1, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < HOLD - 2; i++) step("R6", 1'b1, 1'b0, 1'b0, 1'b0);
    step("R7", 1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < HOLD + 2; i++) step("R7", 1'b1, 1'b0, 1'b0, 1'b0);
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 4000; i++) begin
      bit t, f, b, w;
      t = ($urandom % 3) == 0;
      f = ($urandom % 200) < 3 || (supply_fail && ($urandom % 8) != 0);
      b = ($urandom % 150) == 0;
      w = ($urandom % 170) == 0;
      step("R7", t, f, b, w);
    end
    por_n = 1'b0;
    m_active = 1'b1; m_left = HOLD; m_rel = 1'b0;
    #1;
    check_all("R1");
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired R1 actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule